// File: doc/BRIEF.md
# Parallel Host Command Port

This block is the device end of an asynchronous parallel microprocessor bus. An external host writes command words and data words into it, and reads data words and a status word back. A single address line separates the two kinds of access: address high means command (on a write) or status (on a read), and address low means a data word in either direction. The host can connect in one of two ways. It can use separate active-low read and write strobes, or it can use one read/write level that is qualified by an active-low data strobe. Chip select gates both styles. An optional wait output holds the host off while the device's internal side finishes a handshake.

The port frames commands itself. The low bits of each command word index a small parameter table that gives how many data words follow that command (0 to 4). Words that are written are handed to internal logic on valid/ready channels, one for commands and one for data. A data read is fetched through a request/acknowledge pair. The address line carries more than a register select. Any write with address high throws away the framing in progress and starts a new command. A status read with address high never alters the framing.

All bus inputs pass through two-flop synchronisers. A write and a data-word count take effect once, on the synchronised ending edge of the strobe. A read fetches its word on the synchronised leading edge, so that the word is ready while the strobe is still held.

Top module: `pbus_cmd_port`

## Requirements
- R1: A write with address high delivers the written word once on the command channel. Its low two bits select the data-word count from the default table: code 0 gives 0 words, 1 gives 1, 2 gives 2 and 3 gives 4.
- R2: While a command still expects data words, a write with address low delivers the word once on the data channel. It consumes one expected word.
- R3: A write with address high while data words are still pending is taken as a new command, and its count replaces the remaining count.
- R4: A read with address high returns the status word and leaves the framing untouched. In that word, bit 0 is command-in-progress, bit 1 is the interrupt input level and bit 2 is the wait level. All other bits are zero.
- R5: When no data words are pending, a write with address low is taken as a command.
- R6: A command whose count is zero leaves command-in-progress clear right away.
- R7: A read with address low returns the word supplied on the internal read channel. If a command is in progress, the read consumes one expected data word.
- R8: The read-data enable is high only while chip select is low and the access is qualified as a read. Split mode qualifies a read by a low read strobe. Combined mode qualifies it by the read/write level high together with a low data strobe.
- R9: When the wait output is enabled, it is high while a captured word or a read fetch awaits the internal handshake. When it is disabled, it stays low.
- R10: After reset no channel is valid, wait is low, the read-data enable is low and no command is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Device clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_cs_n | input | 1 | Active-low chip select |
| bus_rdn_rw | input | 1 | Read strobe (split mode) or read/write level, high = read (combined mode) |
| bus_wrn_dsn | input | 1 | Write strobe (split mode) or data strobe (combined mode), active low |
| bus_addr | input | 1 | Address line: high = command/status, low = data |
| bus_d_i | input | DW | Bus data into the device |
| bus_d_o | output | DW | Bus data out of the device |
| bus_d_oe | output | 1 | Tri-state enable for bus_d_o |
| bus_wait | output | 1 | Wait to the host, active high |
| irq_level | input | 1 | Interrupt line level reported in status |
| cmd_valid | output | 1 | Command word valid |
| cmd_ready | input | 1 | Internal logic accepts the command |
| cmd_word | output | DW | Command word |
| wr_valid | output | 1 | Written data word valid |
| wr_ready | input | 1 | Internal logic accepts the data word |
| wr_word | output | DW | Written data word |
| rd_req | output | 1 | Request for a read data word |
| rd_ack | input | 1 | Read word present on rd_word |
| rd_word | input | DW | Read data word from internal logic |

## Verification
The stimulus has two parts. A directed sequence builds a four-word command, interrupts it with status reads and then with a new command, lets it run out, and issues a zero-count command and a read command. This separates address-driven restarts from count-driven command detection. Seeded random mixes of reads and writes, with random address levels and interrupt levels, then compare the channel outputs against a framing model in the bench. Each access drives two instances at the same time: one in split-strobe mode with wait and random back-pressure, and one in combined mode without wait. A difference between the two points to the strobe qualification alone.

// File: rtl/pbus_pkg.sv
package pbus_pkg;

    typedef enum logic {
        STRB_SPLIT = 1'b0,
        STRB_RWDS  = 1'b1
    } strobe_mode_e;

    localparam int CNT_W   = 3;
    localparam int ST_BUSY = 0;
    localparam int ST_IRQ  = 1;
    localparam int ST_WAIT = 2;

    typedef struct packed {
        logic rd_on;
        logic wr_on;
    } qual_t;

    // Turns the raw select/strobe levels into read and write qualifiers.
    function automatic qual_t qualify(strobe_mode_e m, logic cs_n, logic a, logic b);
        qual_t q;
        if (m == STRB_SPLIT) begin
            q.rd_on = !cs_n && !a;
            q.wr_on = !cs_n && !b;
        end else begin
            q.rd_on = !cs_n && a && !b;
            q.wr_on = !cs_n && !a && !b;
        end
        return q;
    endfunction

endpackage

// File: rtl/pbus_sync.sv
module pbus_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);

    for (genvar i = 0; i < W; i++) begin : g_bit
        logic [1:0] ff_d, ff_q;

        always_comb begin
            ff_d = {ff_q[0], din[i]};
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) ff_q <= 2'b11;
            else        ff_q <= ff_d;
        end

        assign dout[i] = ff_q[1];
    end

endmodule

// File: rtl/pbus_strobe_decode.sv
module pbus_strobe_decode
    import pbus_pkg::*;
#(
    parameter int           DW   = 16,
    parameter strobe_mode_e MODE = STRB_SPLIT
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          s_cs_n,
    input  logic          s_a,
    input  logic          s_b,
    input  logic          s_addr,
    input  logic [DW-1:0] s_data,
    output logic          rd_start,
    output logic          rd_end,
    output logic          wr_end,
    output logic          ev_addr,
    output logic [DW-1:0] ev_data
);

    typedef struct packed {
        logic          rd_on;
        logic          wr_on;
        logic          addr;
        logic [DW-1:0] data;
    } dec_t;

    dec_t  st_d, st_q;
    qual_t now;

    always_comb begin
        now        = qualify(MODE, s_cs_n, s_a, s_b);
        st_d       = st_q;
        st_d.rd_on = now.rd_on;
        st_d.wr_on = now.wr_on;
        if (now.rd_on || now.wr_on) begin
            st_d.addr = s_addr;
            st_d.data = s_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_start = now.rd_on && !st_q.rd_on;
    assign rd_end   = !now.rd_on && st_q.rd_on;
    assign wr_end   = !now.wr_on && st_q.wr_on;
    // On a leading edge the held copy is stale, so take the live address.
    assign ev_addr  = rd_start ? s_addr : st_q.addr;
    assign ev_data  = st_q.data;

endmodule

// File: rtl/pbus_framer.sv
module pbus_framer
    import pbus_pkg::*;
#(
    parameter int                                CODE_BITS = 2,
    parameter logic [(2**CODE_BITS)*CNT_W-1:0]  LEN_TABLE = {3'd4, 3'd2, 3'd1, 3'd0}
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 wr_end,
    input  logic                 rd_end,
    input  logic                 ev_addr,
    input  logic [CODE_BITS-1:0] ev_code,
    output logic                 cmd_take,
    output logic                 data_take,
    output logic                 busy
);

    logic [CNT_W-1:0] rem_d, rem_q;

    assign busy      = (rem_q != '0);
    assign cmd_take  = wr_end && (ev_addr || !busy);
    assign data_take = wr_end && !cmd_take;

    always_comb begin
        rem_d = rem_q;
        if (cmd_take) begin
            rem_d = LEN_TABLE[int'(ev_code)*CNT_W +: CNT_W];
        end else if (data_take || (rd_end && !ev_addr && busy)) begin
            rem_d = rem_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rem_q <= '0;
        else        rem_q <= rem_d;
    end

endmodule

// File: rtl/pbus_cmd_port.sv
module pbus_cmd_port
    import pbus_pkg::*;
#(
    parameter int                               DW          = 16,
    parameter strobe_mode_e                     STROBE_MODE = STRB_SPLIT,
    parameter bit                               USE_WAIT    = 1'b1,
    parameter int                               CODE_BITS   = 2,
    parameter logic [(2**CODE_BITS)*CNT_W-1:0] LEN_TABLE   = {3'd4, 3'd2, 3'd1, 3'd0}
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_cs_n,
    input  logic          bus_rdn_rw,
    input  logic          bus_wrn_dsn,
    input  logic          bus_addr,
    input  logic [DW-1:0] bus_d_i,
    output logic [DW-1:0] bus_d_o,
    output logic          bus_d_oe,
    output logic          bus_wait,
    input  logic          irq_level,
    output logic          cmd_valid,
    input  logic          cmd_ready,
    output logic [DW-1:0] cmd_word,
    output logic          wr_valid,
    input  logic          wr_ready,
    output logic [DW-1:0] wr_word,
    output logic          rd_req,
    input  logic          rd_ack,
    input  logic [DW-1:0] rd_word
);

    localparam int SW = DW + 4;

    typedef struct packed {
        logic          cmd_valid;
        logic [DW-1:0] cmd_word;
        logic          wr_valid;
        logic [DW-1:0] wr_word;
        logic          rd_req;
        logic [DW-1:0] dout;
    } port_t;

    logic [SW-1:0] sync_out;
    logic          rd_start, rd_end, wr_end, ev_addr;
    logic [DW-1:0] ev_data;
    logic          cmd_take, data_take, busy;
    logic          pending, wait_w;
    logic [DW-1:0] status_w;
    qual_t         pin_q;
    port_t         p_d, p_q;

    pbus_sync #(.W(SW)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  ({bus_cs_n, bus_rdn_rw, bus_wrn_dsn, bus_addr, bus_d_i}),
        .dout (sync_out)
    );

    pbus_strobe_decode #(.DW(DW), .MODE(STROBE_MODE)) u_dec (
        .clk     (clk),
        .rst_n   (rst_n),
        .s_cs_n  (sync_out[DW+3]),
        .s_a     (sync_out[DW+2]),
        .s_b     (sync_out[DW+1]),
        .s_addr  (sync_out[DW]),
        .s_data  (sync_out[DW-1:0]),
        .rd_start(rd_start),
        .rd_end  (rd_end),
        .wr_end  (wr_end),
        .ev_addr (ev_addr),
        .ev_data (ev_data)
    );

    pbus_framer #(.CODE_BITS(CODE_BITS), .LEN_TABLE(LEN_TABLE)) u_frm (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_end   (wr_end),
        .rd_end   (rd_end),
        .ev_addr  (ev_addr),
        .ev_code  (ev_data[CODE_BITS-1:0]),
        .cmd_take (cmd_take),
        .data_take(data_take),
        .busy     (busy)
    );

    assign pending = p_q.cmd_valid || p_q.wr_valid || p_q.rd_req;

    if (USE_WAIT) begin : g_wait
        assign wait_w = pending;
    end else begin : g_nowait
        assign wait_w = 1'b0;
    end

    always_comb begin
        status_w          = '0;
        status_w[ST_BUSY] = busy;
        status_w[ST_IRQ]  = irq_level;
        status_w[ST_WAIT] = wait_w;
    end

    always_comb begin
        p_d = p_q;
        if (p_q.cmd_valid && cmd_ready) p_d.cmd_valid = 1'b0;
        if (p_q.wr_valid && wr_ready)   p_d.wr_valid  = 1'b0;
        if (cmd_take) begin
            p_d.cmd_valid = 1'b1;
            p_d.cmd_word  = ev_data;
        end
        if (data_take) begin
            p_d.wr_valid = 1'b1;
            p_d.wr_word  = ev_data;
        end
        if (p_q.rd_req && rd_ack) begin
            p_d.rd_req = 1'b0;
            p_d.dout   = rd_word;
        end
        if (rd_start) begin
            if (ev_addr) p_d.dout   = status_w;
            else         p_d.rd_req = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q <= '0;
        else        p_q <= p_d;
    end

    always_comb begin
        pin_q = qualify(STROBE_MODE, bus_cs_n, bus_rdn_rw, bus_wrn_dsn);
    end

    assign bus_d_oe  = pin_q.rd_on;
    assign bus_d_o   = p_q.dout;
    assign bus_wait  = wait_w;
    assign cmd_valid = p_q.cmd_valid;
    assign cmd_word  = p_q.cmd_word;
    assign wr_valid  = p_q.wr_valid;
    assign wr_word   = p_q.wr_word;
    assign rd_req    = p_q.rd_req;

endmodule

// File: rtl/pbus_cmd_port_chk.sv
module pbus_cmd_port_chk #(
    parameter int DW       = 16,
    parameter bit USE_WAIT = 1'b1
) (
    input logic          clk,
    input logic          rst_n,
    input logic          bus_cs_n,
    input logic          bus_d_oe,
    input logic          bus_wait,
    input logic          cmd_valid,
    input logic          cmd_ready,
    input logic [DW-1:0] cmd_word,
    input logic          wr_valid,
    input logic          wr_ready,
    input logic [DW-1:0] wr_word,
    input logic          rd_req,
    input logic          rd_ack
);

    // R1
    cmd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_word));

    // R2
    wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && !wr_ready |=> wr_valid && $stable(wr_word));

    // R3
    one_kind_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cmd_valid) |-> !$rose(wr_valid));

    // R7
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req && !rd_ack |=> rd_req);

    // R8
    oe_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_d_oe |-> !bus_cs_n);

    // R9
    wait_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        USE_WAIT && rd_req && !rd_ack |-> bus_wait);

    // R9
    wait_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        USE_WAIT && cmd_valid |-> bus_wait);

endmodule

bind pbus_cmd_port pbus_cmd_port_chk #(.DW(DW), .USE_WAIT(USE_WAIT)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_cs_n (bus_cs_n),
    .bus_d_oe (bus_d_oe),
    .bus_wait (bus_wait),
    .cmd_valid(cmd_valid),
    .cmd_ready(cmd_ready),
    .cmd_word (cmd_word),
    .wr_valid (wr_valid),
    .wr_ready (wr_ready),
    .wr_word  (wr_word),
    .rd_req   (rd_req),
    .rd_ack   (rd_ack)
);

// File: tb/pbus_cmd_port_bench.sv
module pbus_cmd_port_bench;
    import pbus_pkg::*;

    localparam int DW = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic          h_cs_n = 1'b1, h_rd = 1'b0, h_wr = 1'b0, h_addr = 1'b0;
    logic [DW-1:0] h_data = '0, h_rword = '0;
    logic          h_irq = 1'b0;

    logic [DW-1:0] d_o1, d_o2, cw1, cw2, ww1, ww2;
    logic          oe1, oe2, wait1, wait2, cv1, cv2, wv1, wv2, rq1, rq2;
    logic          crdy1 = 1'b0, wrdy1 = 1'b0, ack1 = 1'b0;

    pbus_cmd_port #(.DW(DW), .STROBE_MODE(STRB_SPLIT), .USE_WAIT(1'b1)) u_pbus_cmd_port (
        .clk(clk), .rst_n(rst_n), .bus_cs_n(h_cs_n), .bus_rdn_rw(~h_rd), .bus_wrn_dsn(~h_wr),
        .bus_addr(h_addr), .bus_d_i(h_data), .bus_d_o(d_o1), .bus_d_oe(oe1), .bus_wait(wait1),
        .irq_level(h_irq), .cmd_valid(cv1), .cmd_ready(crdy1), .cmd_word(cw1),
        .wr_valid(wv1), .wr_ready(wrdy1), .wr_word(ww1), .rd_req(rq1), .rd_ack(ack1),
        .rd_word(h_rword)
    );

    pbus_cmd_port #(.DW(DW), .STROBE_MODE(STRB_RWDS), .USE_WAIT(1'b0)) u_pbus_cmd_port_rw (
        .clk(clk), .rst_n(rst_n), .bus_cs_n(h_cs_n), .bus_rdn_rw(h_rd), .bus_wrn_dsn(~(h_rd | h_wr)),
        .bus_addr(h_addr), .bus_d_i(h_data), .bus_d_o(d_o2), .bus_d_oe(oe2), .bus_wait(wait2),
        .irq_level(h_irq), .cmd_valid(cv2), .cmd_ready(1'b1), .cmd_word(cw2),
        .wr_valid(wv2), .wr_ready(1'b1), .wr_word(ww2), .rd_req(rq2), .rd_ack(1'b1),
        .rd_word(h_rword)
    );

    int nvec = 0, nbad = 0;
    int n_cmd1 = 0, n_cmd2 = 0, n_dat1 = 0, n_dat2 = 0;
    logic [DW-1:0] last_cmd1 = '0, last_cmd2 = '0, last_dat1 = '0, last_dat2 = '0;
    bit seen_w1 = 1'b0, seen_w2 = 1'b0;
    int rem_m = 0;

    always @(posedge clk) begin
        if (cv1 && crdy1) begin n_cmd1 <= n_cmd1 + 1; last_cmd1 <= cw1; end
        if (wv1 && wrdy1) begin n_dat1 <= n_dat1 + 1; last_dat1 <= ww1; end
        if (cv2) begin n_cmd2 <= n_cmd2 + 1; last_cmd2 <= cw2; end
        if (wv2) begin n_dat2 <= n_dat2 + 1; last_dat2 <= ww2; end
        if (wait1) seen_w1 <= 1'b1;
        if (wait2) seen_w2 <= 1'b1;
    end

    // Random back-pressure on the split-mode instance.
    always @(negedge clk) begin
        crdy1 <= ($urandom % 3) == 0;
        wrdy1 <= ($urandom % 3) == 0;
        ack1  <= ($urandom % 4) == 0;
    end

    function automatic int len_of(logic [DW-1:0] code);
        case (code[1:0])
            2'd0: return 0;
            2'd1: return 1;
            2'd2: return 2;
            default: return 4;
        endcase
    endfunction

    function automatic logic [DW-1:0] status_of(bit busy, logic irq);
        logic [DW-1:0] s = '0;
        s[0] = busy;
        s[1] = irq;
        return s;
    endfunction

    task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
        nvec++;
        if (!ok) begin
            nbad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic do_wr(bit a, logic [DW-1:0] d);
        int  c1 = n_cmd1, c2 = n_cmd2, e1 = n_dat1, e2 = n_dat2;
        bit  is_cmd = a || (rem_m == 0);
        string tag = !is_cmd ? "R2" : (!a ? "R5" : (rem_m != 0 ? "R3" : "R1"));
        @(negedge clk);
        h_cs_n = 1'b0; h_addr = a; h_data = d; h_wr = 1'b1;
        repeat (6) @(negedge clk);
        chk(!oe1 && !oe2, "R8", {oe1, oe2}, 0);
        h_wr = 1'b0;
        repeat (4) @(negedge clk);
        h_cs_n = 1'b1;
        repeat (6) @(negedge clk);
        while (wait1) @(negedge clk);
        repeat (3) @(negedge clk);
        if (is_cmd) begin
            rem_m = len_of(d);
            chk(n_cmd1 == c1 + 1 && last_cmd1 == d && n_dat1 == e1, tag, last_cmd1, d);
            chk(n_cmd2 == c2 + 1 && last_cmd2 == d && n_dat2 == e2, tag, last_cmd2, d);
        end else begin
            rem_m = rem_m - 1;
            chk(n_dat1 == e1 + 1 && last_dat1 == d && n_cmd1 == c1, tag, last_dat1, d);
            chk(n_dat2 == e2 + 1 && last_dat2 == d && n_cmd2 == c2, tag, last_dat2, d);
        end
    endtask

    task automatic do_rd(bit a, string tag);
        logic [DW-1:0] exp;
        h_rword = DW'($urandom);
        exp = a ? status_of(rem_m != 0, h_irq) : h_rword;
        @(negedge clk);
        h_cs_n = 1'b0; h_addr = a; h_rd = 1'b1;
        repeat (6) @(negedge clk);
        while (wait1) @(negedge clk);
        repeat (3) @(negedge clk);
        chk(d_o1 == exp, tag, d_o1, exp);
        chk(d_o2 == exp, tag, d_o2, exp);
        chk(oe1 && oe2, "R8", {oe1, oe2}, 3);
        h_rd = 1'b0;
        repeat (4) @(negedge clk);
        chk(!oe1 && !oe2, "R8", {oe1, oe2}, 0);
        h_cs_n = 1'b1;
        repeat (6) @(negedge clk);
        if (!a && rem_m > 0) rem_m = rem_m - 1;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nbad++;
        $display("FAIL watchdog act=0 exp=1");
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

    initial begin
        void'($urandom(32'h5eed));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        // R10 reset state
        chk(!wait1 && !wait2 && !cv1 && !wv1 && !rq1 && !oe1, "R10",
            {wait1, wait2, cv1, wv1, rq1, oe1}, 0);
        do_rd(1'b1, "R10");

        // Directed framing sequence
        do_wr(1'b1, 16'h0013);          // R1: 4 data words follow
        h_irq = 1'b1;
        do_rd(1'b1, "R4");              // busy + irq
        do_wr(1'b0, 16'hA001);          // R2
        do_rd(1'b1, "R4");              // status read does not advance
        do_wr(1'b0, 16'hA002);          // R2
        do_wr(1'b1, 16'h0021);          // R3: restart, 1 word
        do_wr(1'b0, 16'hB001);          // R2
        do_wr(1'b0, 16'h0040);          // R5: count done, code 0
        do_rd(1'b1, "R6");              // zero words: busy clear
        h_irq = 1'b0;
        do_wr(1'b1, 16'h0002);          // 2 words
        do_rd(1'b0, "R7");
        do_rd(1'b0, "R7");
        do_rd(1'b1, "R7");              // count consumed by reads
        chk(seen_w1, "R9", seen_w1, 1);

        // Seeded random mix
        for (int i = 0; i < 150; i++) begin
            bit a  = ($urandom % 3) == 0;
            bit rd = ($urandom % 3) == 0;
            h_irq = 1'($urandom);
            if (rd) do_rd(a, a ? "R4" : "R7");
            else    do_wr(a, DW'($urandom));
        end
        chk(!seen_w2, "R9", seen_w2, 0);

        $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
        $finish;
    end

endmodule